// File: doc/BRIEF.md
# Scanned Key Matrix Encoder

This block reads a grid of key switches by driving one column line at a time and comparing the returned row lines against the current row scan position. The column and row scan positions advance together as a two-stage sweep that visits one crosspoint per clock. When the visited crosspoint is closed, the sweep freezes. A debounce counter then checks that the closure is steady. Once it is, the block latches an 8-bit code and a parity bit from an internal code table and raises a strobe.

The code table has three banks. The shift and control inputs choose the bank, and the frozen crosspoint chooses the word within it. The data and the strobe stay fixed until the key opens. When the key opens, the strobe drops and the sweep continues from where it stopped. Two inputs set the output polarity: one inverts the data and the strobe together, the other inverts only the parity bit.

Top module: `kbd_matrix_encoder`

## Requirements
- R1: While `rst_ni` is low, and at the first falling clock edge after it goes high, `col_o` is 8'h01. With both invert inputs low, `strobe_o` is 0, `data_o` is 0 and `parity_o` is 1.
- R2: With no key closed, `col_o` is one-hot. Each column is driven for 11 consecutive cycles, and the columns follow the order 0,1,...,7,0.
- R3: While the crosspoint being visited is closed (row line `row_i[r]` high while the row scan is at stage r), the scan holds: `col_o` does not change.
- R4: After a closed crosspoint is first visited, `strobe_o` rises after exactly DEBOUNCE clock edges of continuous closure. For a key at row r, with the key already closed when its column becomes active (cycle 0), the strobe is seen at cycle r+DEBOUNCE. A closure shorter than DEBOUNCE edges never raises the strobe.
- R5: The bank is 2 when `ctrl_i` is high (control wins over shift), 1 when only `shift_i` is high, and 0 otherwise. The code is (col*11 + row + 100*bank) mod 256. The bank is sampled at the edge where the strobe rises.
- R6: While the strobe is active, `data_o` and `parity_o` hold their values, even if `shift_i` or `ctrl_i` change.
- R7: When the key opens, the strobe goes inactive one edge later, and the scan resumes from the next row stage. For a key at row r, `col_o` moves to the next column at the (11-r)-th falling edge after release.
- R8: The parity bit makes the 9-bit total {parity, data} contain an odd number of ones, computed on the uninverted table data. `par_inv_i` high inverts `parity_o`.
- R9: `data_inv_i` high inverts all 8 bits of `data_o` and the strobe level. It does not affect `parity_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| col_o | output | 8 | One-hot column drive |
| row_i | input | 11 | Returned row lines, high = switch closed on the driven column |
| shift_i | input | 1 | Shift bank select |
| ctrl_i | input | 1 | Control bank select, takes priority over shift |
| data_inv_i | input | 1 | Invert data and strobe |
| par_inv_i | input | 1 | Invert parity |
| data_o | output | 8 | Key code |
| parity_o | output | 1 | Odd parity of the code |
| strobe_o | output | 1 | Data valid (active high unless inverted) |

## Verification
The hardest situation to reach is a closure that ends one edge before the debounce count completes. It is reached only if the stimulus knows when the hidden row scan arrives at the key. The bench closes the key before its column becomes active, takes the first cycle of that column as cycle 0, and uses the row index to place the match cycle, the strobe edge and the release exactly. The same alignment gives the exact debounce latency and the exact cycle at which the scan resumes after release.

// File: rtl/kbd_enc_pkg.sv
package kbd_enc_pkg;
  localparam int NUM_BANKS = 3;
  typedef enum logic [1:0] {
    BANK_PLAIN = 2'd0,
    BANK_SHIFT = 2'd1,
    BANK_CTRL  = 2'd2
  } bank_e;

  function automatic bank_e pick_bank(input logic shift, input logic ctrl);
    if (ctrl) return BANK_CTRL;
    if (shift) return BANK_SHIFT;
    return BANK_PLAIN;
  endfunction
endpackage

// File: rtl/kbd_ring.sv
module kbd_ring #(
  parameter int STAGES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [STAGES-1:0] ring_o
);
  generate
    if (STAGES == 1) begin : g_single
      assign ring_o = 1'b1;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    ring_o <= STAGES'(1);
        else if (adv_i) ring_o <= {ring_o[STAGES-2:0], ring_o[STAGES-1]};
      end
    end
  endgenerate

  // R2
  ring_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ring_o) == 1);
endmodule

// File: rtl/kbd_code_rom.sv
module kbd_code_rom
  import kbd_enc_pkg::*;
#(
  parameter int NUM_KEYS    = 88,
  parameter int BANK_STRIDE = 100,
  localparam int DEPTH = NUM_BANKS * NUM_KEYS,
  localparam int AW    = $clog2(DEPTH),
  localparam int KW    = $clog2(NUM_KEYS)
) (
  input  bank_e         bank_i,
  input  logic [KW-1:0] key_i,
  output logic [7:0]    data_o,
  output logic          parity_o
);
  logic [7:0] mem [DEPTH];
  logic [AW-1:0] addr;

  initial begin
    for (int b = 0; b < NUM_BANKS; b++)
      for (int k = 0; k < NUM_KEYS; k++)
        mem[b*NUM_KEYS + k] = 8'((k + b*BANK_STRIDE) % 256);
  end

  assign addr     = AW'(bank_i) * AW'(NUM_KEYS) + AW'(key_i);
  assign data_o   = mem[addr];
  assign parity_o = ~^data_o;  // odd over 9 bits
endmodule

// File: rtl/kbd_debounce.sv
module kbd_debounce #(
  parameter int DEBOUNCE = 4,
  localparam int CW = $clog2(DEBOUNCE + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  output logic load_o,
  output logic strobe_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!match_i)                 cnt_q <= '0;
    else if (cnt_q != CW'(DEBOUNCE))   cnt_q <= cnt_q + 1'b1;
  end

  assign load_o   = match_i && (cnt_q == CW'(DEBOUNCE - 1));
  assign strobe_o = (cnt_q == CW'(DEBOUNCE));

  // R4
  strobe_needs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_o) |-> $past(match_i));
  // R7
  release_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && !match_i) |=> !strobe_o);
endmodule

// File: rtl/kbd_matrix_encoder.sv
module kbd_matrix_encoder
  import kbd_enc_pkg::*;
#(
  parameter int NUM_COLS    = 8,
  parameter int NUM_ROWS    = 11,
  parameter int DEBOUNCE    = 4,
  parameter int BANK_STRIDE = 100,
  localparam int NUM_KEYS = NUM_COLS * NUM_ROWS,
  localparam int KW       = $clog2(NUM_KEYS),
  localparam int CIW      = $clog2(NUM_COLS),
  localparam int RIW      = $clog2(NUM_ROWS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [NUM_COLS-1:0] col_o,
  input  logic [NUM_ROWS-1:0] row_i,
  input  logic                shift_i,
  input  logic                ctrl_i,
  input  logic                data_inv_i,
  input  logic                par_inv_i,
  output logic [7:0]          data_o,
  output logic                parity_o,
  output logic                strobe_o
);
  logic [NUM_COLS-1:0] col_ring;
  logic [NUM_ROWS-1:0] row_ring;
  logic                match_w, load_w, strobe_w;
  logic [CIW-1:0]      col_idx;
  logic [RIW-1:0]      row_idx;
  logic [KW-1:0]       key_idx;
  logic [7:0]          rom_data, data_q;
  logic                rom_par, par_q;

  assign match_w = |(row_i & row_ring);

  kbd_ring #(.STAGES(NUM_ROWS)) u_row_ring (
    .clk_i, .rst_ni, .adv_i(!match_w), .ring_o(row_ring)
  );
  kbd_ring #(.STAGES(NUM_COLS)) u_col_ring (
    .clk_i, .rst_ni, .adv_i(!match_w && row_ring[NUM_ROWS-1]), .ring_o(col_ring)
  );

  always_comb begin
    col_idx = '0;
    for (int i = 0; i < NUM_COLS; i++) if (col_ring[i]) col_idx = CIW'(i);
    row_idx = '0;
    for (int j = 0; j < NUM_ROWS; j++) if (row_ring[j]) row_idx = RIW'(j);
  end

  assign key_idx = KW'(col_idx) * KW'(NUM_ROWS) + KW'(row_idx);

  kbd_code_rom #(.NUM_KEYS(NUM_KEYS), .BANK_STRIDE(BANK_STRIDE)) u_rom (
    .bank_i(pick_bank(shift_i, ctrl_i)), .key_i(key_idx),
    .data_o(rom_data), .parity_o(rom_par)
  );

  kbd_debounce #(.DEBOUNCE(DEBOUNCE)) u_debounce (
    .clk_i, .rst_ni, .match_i(match_w), .load_o(load_w), .strobe_o(strobe_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      par_q  <= 1'b1;
    end else if (load_w) begin
      data_q <= rom_data;
      par_q  <= rom_par;
    end
  end

  assign col_o    = col_ring;
  assign data_o   = data_q ^ {8{data_inv_i}};
  assign parity_o = par_q ^ par_inv_i;
  assign strobe_o = strobe_w ^ data_inv_i;

  // R3
  scan_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_w |=> ($stable(col_ring) && $stable(row_ring)));
  // R2
  scan_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_w |=> !$stable(row_ring));
  // R6
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_w && $past(strobe_w)) |-> ($stable(data_q) && $stable(par_q)));
  // R8
  parity_odd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_w |-> ($countones({par_q, data_q}) % 2 == 1));
endmodule

// File: tb/kbd_matrix_encoder_tb_top.sv
`timescale 1ns/1ps
module kbd_matrix_encoder_tb_top;
  localparam int NC = 8, NR = 11, DB = 4, STRIDE = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] col_o;
  logic [NR-1:0] row_i;
  logic shift = 0, ctrl = 0, dinv = 0, pinv = 0;
  logic [7:0] data_o;
  logic parity_o, strobe_o;

  logic key_on = 0;
  int key_c = 0, key_r = 0;
  int n_chk = 0, n_bad = 0;
  logic [8:0] exp_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  assign row_i = (key_on && col_o[key_c]) ? (NR'(1) << key_r) : '0;

  kbd_matrix_encoder #(.DEBOUNCE(DB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .col_o(col_o), .row_i(row_i),
    .shift_i(shift), .ctrl_i(ctrl), .data_inv_i(dinv), .par_inv_i(pinv),
    .data_o(data_o), .parity_o(parity_o), .strobe_o(strobe_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [8:0] model(input int c, input int r, input bit sh,
                                       input bit ct, input bit di, input bit pi);
    int bank = ct ? 2 : (sh ? 1 : 0);
    logic [7:0] d = 8'((c*NR + r + bank*STRIDE) % 256);
    logic p = ~^d;
    return {p ^ pi, d ^ {8{di}}};
  endfunction

  // monitor / scoreboard: R5 R8 R9
  logic prev_sb = 0;
  always @(negedge clk) begin
    logic sb;
    logic [8:0] e;
    if (rst_n) begin
      sb = strobe_o ^ dinv;
      if (sb && !prev_sb) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected strobe", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk({parity_o, data_o} == e, "R5/R8/R9 code", int'({parity_o, data_o}), int'(e));
        end
      end
      prev_sb = sb;
    end else prev_sb = 0;
  end

  task automatic wait_col(input int c);
    int g = 0;
    while (col_o != NC'(1) << c && g < 200) begin @(negedge clk); g++; end
  endtask

  task automatic leave_col(input int c);
    int g = 0;
    while (col_o == NC'(1) << c && g < 200) begin @(negedge clk); g++; end
  endtask

  task automatic press(input int c, input int r, input bit sh, input bit ct,
                       input bit di, input bit pi);
    int t, n;
    logic [7:0] hd;
    logic hp;
    leave_col(c);
    shift = sh; ctrl = ct; dinv = di; pinv = pi;
    key_c = c; key_r = r; key_on = 1;
    exp_q.push_back(model(c, r, sh, ct, di, pi));
    wait_col(c);
    t = 0;
    while (!(strobe_o ^ dinv) && t < 200) begin @(negedge clk); t++; end
    chk(t == r + DB, "R4 debounce latency", t, r + DB);
    // R3 R6: hold while toggling bank selects
    hd = data_o; hp = parity_o;
    n = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      shift = ~shift; ctrl = (i % 3 == 0) ? ~ctrl : ctrl;
      if (col_o != NC'(1) << c) n++;
      if (data_o != hd || parity_o != hp) n++;
    end
    @(negedge clk);
    chk(col_o == NC'(1) << c, "R3 scan frozen", int'(col_o), int'(NC'(1) << c));
    chk(n == 0 && data_o == hd && parity_o == hp, "R6 data held", n, 0);
    // R7 release
    key_on = 0;
    @(negedge clk);
    chk(!(strobe_o ^ dinv), "R7 strobe drop", int'(strobe_o ^ dinv), 0);
    n = 1;
    while (col_o == NC'(1) << c && n < 50) begin @(negedge clk); n++; end
    chk(n == NR - r, "R7 scan resume", n, NR - r);
  endtask

  task automatic bounce(input int c, input int r);
    int n = 0;
    leave_col(c);
    shift = 0; ctrl = 0; dinv = 0; pinv = 0;
    key_c = c; key_r = r; key_on = 1;
    wait_col(c);
    repeat (r + DB - 1) @(negedge clk);
    key_on = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (strobe_o) n++;
    end
    chk(n == 0, "R4 short closure ignored", n, 0);
  endtask

  initial begin
    int errs;
    repeat (3) @(negedge clk);
    // R1
    chk(col_o == 8'h01 && !strobe_o && data_o == 0 && parity_o,
        "R1 reset state", int'({col_o, strobe_o, data_o, parity_o}), int'({8'h01, 1'b0, 8'h00, 1'b1}));
    rst_n = 1;
    chk(col_o == 8'h01 && !strobe_o, "R1 after reset", int'(col_o), 1);
    // R2 idle sweep
    errs = 0;
    for (int t = 0; t < 2*NC*NR; t++) begin
      if (col_o != NC'(1) << ((t / NR) % NC) || strobe_o) errs++;
      @(negedge clk);
    end
    chk(errs == 0, "R2 idle column sweep", errs, 0);

    press(0, 0, 0, 0, 0, 0);
    press(3, 5, 1, 0, 0, 0);
    press(7, 10, 0, 1, 0, 0);
    press(5, 2, 1, 1, 0, 0);   // R5 control priority
    press(2, 7, 0, 0, 1, 0);   // R9
    press(6, 4, 1, 0, 0, 1);   // R8 parity invert
    bounce(4, 3);
    press(1, 9, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all codes seen", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule